// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between a 64-bit register file and a data memory that is 64 bits wide and addressed by byte. For every memory request it does four things:

- It forms the byte address from a base register and a 16-bit displacement.
- It checks that the access is naturally aligned to its size.
- For a store, it drives per-lane write enables and positions the source data on the memory lanes.
- For a load, it selects the addressed field from the memory double word and widens it to 64 bits.

The access size can be a byte, a half word, a word or a double word. A load widens its field with zeros or with copies of the sign bit.

A run-time input chooses the lane ordering, little-endian or big-endian. The memory is read in the same cycle as the request. The load result is registered and comes back one cycle later, together with a valid flag and a fault flag. The address, the fault indication and the store lane signals are combinational on the request.

Top module: `ls_align_unit`

## Requirements
- R1: `addr_o` equals the base value plus the 16-bit displacement sign-extended to 64 bits, wrapping modulo 2^64.
- R2: When `base_idx_i` is 0, the base value is taken as zero and `base_val_i` has no effect on `addr_o`. This gives absolute addressing. A zero displacement gives register-indirect addressing.
- R3: `req_size_i` encodes the access size: 0 = byte, 1 = half word, 2 = word, 3 = double word. An access is misaligned in these cases:
  - a half word with `addr_o[0]` set;
  - a word with `addr_o[1:0]` nonzero;
  - a double word with `addr_o[2:0]` nonzero.
  `fault_o` is 1 exactly when `req_valid_i` is high and the access is misaligned.
- R4: `wr_be_o` is zero whenever any of these holds: `req_valid_i` is low, the request is a load (`req_store_i` = 0), or the access faults.
- R5: For a valid aligned store of n bytes at offset a = `addr_o[2:0]`, `wr_be_o` covers exactly n lanes:
  - little-endian (`big_endian_i` = 0): lanes a through a+n-1;
  - big-endian: lanes 8-a-n through 7-a.
  Lane j is bits [8j+7:8j].
- R6: On a store, `wr_data_o` carries the low n bytes of `store_src_i` in the enabled lanes. Byte i of the source goes to lane a+i in little-endian mode and to lane 8-a-n+i in big-endian mode, so the most significant byte sits at the lowest address. All other lanes are zero.
- R7: On a load, the n bytes of `mem_rdata_i` are gathered using the same lane mapping as R6. The result is zero-extended when `req_unsigned_i` = 1 and sign-extended otherwise. A double word is returned unchanged.
- R8: One cycle after a valid load request, `load_valid_o` is 1 and `load_data_o` holds the result. Stores and idle cycles leave `load_valid_o` at 0 in the following cycle.
- R9: One cycle after a misaligned load, `load_fault_o` is 1 and `load_data_o` is zero.
- R10: After reset, `load_valid_o`, `load_fault_o` and `load_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_unsigned_i | input | 1 | Load widening: 1 = zero, 0 = sign |
| big_endian_i | input | 1 | Lane ordering: 1 = big-endian |
| base_idx_i | input | 5 | Base register number |
| base_val_i | input | 64 | Base register contents |
| disp_i | input | 16 | Signed displacement |
| store_src_i | input | 64 | Store source register |
| mem_rdata_i | input | 64 | Memory read double word |
| addr_o | output | 64 | Effective byte address |
| fault_o | output | 1 | Misaligned request |
| wr_be_o | output | 8 | Store lane enables |
| wr_data_o | output | 64 | Store data on lanes |
| load_valid_o | output | 1 | Load result valid |
| load_fault_o | output | 1 | Load faulted |
| load_data_o | output | 64 | Widened load result |

## Verification
The address, the fault flag, the lane enables and the store data are combinational. The bench therefore drives each request on a falling edge and checks these outputs a nanosecond later, in the same cycle.

The load result, its valid flag and its fault flag come from one register stage. The bench checks them one nanosecond after the next rising edge, and the request is still held at that point. Each request is then removed on the following falling edge, so every registered check refers to exactly one request. Idle cycles between requests confirm that the valid flag returns to zero.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ls_agen.sv
module ls_agen
  import ls_align_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5,
  localparam int LANES = XLEN / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [XLEN-1:0]   base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  acc_size_e         size_i,
  input  logic              big_endian_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              misalign_o,
  output logic [OFF_W-1:0]  lsb_lane_o
);
  logic [XLEN-1:0]  base_eff;
  logic [XLEN-1:0]  disp_ext;
  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   size_mask;
  logic [OFF_W:0]   off_w;
  logic [OFF_W:0]   lsb_w;

  // register 0 reads as zero whatever the file holds
  assign base_eff  = (base_idx_i == '0) ? '0 : base_val_i;
  assign disp_ext  = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign addr_o    = base_eff + disp_ext;

  assign nbytes     = (OFF_W+1)'(1) << size_i;
  assign size_mask  = nbytes - (OFF_W+1)'(1);
  assign off_w      = {1'b0, addr_o[OFF_W-1:0]};
  assign misalign_o = |(off_w & size_mask);

  // lane holding the least significant byte of the field
  assign lsb_w      = big_endian_i ? ((OFF_W+1)'(LANES) - off_w - nbytes) : off_w;
  assign lsb_lane_o = lsb_w[OFF_W-1:0];
endmodule

// File: rtl/ls_store_lanes.sv
module ls_store_lanes
  import ls_align_pkg::*;
#(
  parameter int XLEN   = 64,
  localparam int LANES = XLEN / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  lsb_lane_i,
  input  logic [XLEN-1:0]   src_i,
  output logic [LANES-1:0]  be_o,
  output logic [XLEN-1:0]   data_o
);
  logic [OFF_W:0]   nbytes;
  logic [LANES:0]   run;
  logic [LANES-1:0] fld_be;
  logic [XLEN-1:0]  fld_bits;
  logic [XLEN-1:0]  src_masked;

  assign nbytes = (OFF_W+1)'(1) << size_i;
  assign run    = ((LANES+1)'(1) << nbytes) - (LANES+1)'(1);
  assign fld_be = run[LANES-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_bits
    assign fld_bits[g*8 +: 8] = {8{fld_be[g]}};
  end

  assign src_masked = src_i & fld_bits;
  assign be_o       = en_i ? (fld_be << lsb_lane_i) : '0;
  assign data_o     = src_masked << {lsb_lane_i, 3'b000};
endmodule

// File: rtl/ls_load_extract.sv
module ls_load_extract
  import ls_align_pkg::*;
#(
  parameter int XLEN   = 64,
  localparam int LANES = XLEN / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [XLEN-1:0]   rdata_i,
  input  logic [OFF_W-1:0]  lsb_lane_i,
  input  acc_size_e         size_i,
  input  logic              unsigned_i,
  output logic [XLEN-1:0]   data_o
);
  logic [XLEN-1:0] shifted;

  assign shifted = rdata_i >> {lsb_lane_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(XLEN-8){~unsigned_i & shifted[7]}},   shifted[7:0]};
      SZ_HALF: data_o = {{(XLEN-16){~unsigned_i & shifted[15]}}, shifted[15:0]};
      SZ_WORD: data_o = {{(XLEN-32){~unsigned_i & shifted[31]}}, shifted[31:0]};
      default: data_o = shifted;
    endcase
  end
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
  import ls_align_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5,
  localparam int LANES = XLEN / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic              big_endian_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [XLEN-1:0]   base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   store_src_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              fault_o,
  output logic [LANES-1:0]  wr_be_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              load_valid_o,
  output logic              load_fault_o,
  output logic [XLEN-1:0]   load_data_o
);
  acc_size_e        size;
  logic             misalign;
  logic [OFF_W-1:0] lsb_lane;
  logic             st_en;
  logic             ld_req;
  logic [XLEN-1:0]  ld_ext;
  logic             ld_valid_q, ld_fault_q;
  logic [XLEN-1:0]  ld_data_q;

  assign size = acc_size_e'(req_size_i);

  ls_agen #(.XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)) i_agen (
    .base_idx_i  (base_idx_i),
    .base_val_i  (base_val_i),
    .disp_i      (disp_i),
    .size_i      (size),
    .big_endian_i(big_endian_i),
    .addr_o      (addr_o),
    .misalign_o  (misalign),
    .lsb_lane_o  (lsb_lane)
  );

  assign fault_o = req_valid_i & misalign;
  assign st_en   = req_valid_i & req_store_i & ~misalign;
  assign ld_req  = req_valid_i & ~req_store_i;

  ls_store_lanes #(.XLEN(XLEN)) i_store (
    .en_i      (st_en),
    .size_i    (size),
    .lsb_lane_i(lsb_lane),
    .src_i     (store_src_i),
    .be_o      (wr_be_o),
    .data_o    (wr_data_o)
  );

  ls_load_extract #(.XLEN(XLEN)) i_load (
    .rdata_i   (mem_rdata_i),
    .lsb_lane_i(lsb_lane),
    .size_i    (size),
    .unsigned_i(req_unsigned_i),
    .data_o    (ld_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_q <= 1'b0;
      ld_fault_q <= 1'b0;
      ld_data_q  <= '0;
    end else begin
      ld_valid_q <= ld_req;
      ld_fault_q <= ld_req & misalign;
      if (ld_req) ld_data_q <= misalign ? '0 : ld_ext;
    end
  end

  assign load_valid_o = ld_valid_q;
  assign load_fault_o = ld_fault_q;
  assign load_data_o  = ld_data_q;
endmodule

// File: rtl/ls_align_unit_chk.sv
module ls_align_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_store_i,
  input logic [1:0]  req_size_i,
  input logic        fault_o,
  input logic [7:0]  wr_be_o,
  input logic        load_valid_o,
  input logic        load_fault_o,
  input logic [63:0] load_data_o
);
  p_be_off_on_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> wr_be_o == 8'h00);
  p_be_off_on_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_store_i) |-> wr_be_o == 8'h00);
  p_be_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_be_o != 8'h00) |-> $countones(wr_be_o) == (32'd1 << req_size_i));
  p_fault_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> req_valid_i && req_size_i != 2'd0);
  p_load_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> load_valid_o);
  p_no_spurious_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_store_i) |=> !load_valid_o);
  p_fault_zero_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fault_o |-> load_valid_o && load_data_o == 64'd0);
endmodule

bind ls_align_unit ls_align_unit_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .req_size_i  (req_size_i),
  .fault_o     (fault_o),
  .wr_be_o     (wr_be_o),
  .load_valid_o(load_valid_o),
  .load_fault_o(load_fault_o),
  .load_data_o (load_data_o)
);

// File: tb/test_ls_align_unit.sv
module test_ls_align_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_unsigned_i = 1'b0, big_endian_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [4:0]  base_idx_i = 5'd0;
  logic [63:0] base_val_i = '0, store_src_i = '0, mem_rdata_i = '0;
  logic [15:0] disp_i = '0;
  logic [63:0] addr_o, wr_data_o, load_data_o;
  logic        fault_o, load_valid_o, load_fault_o;
  logic [7:0]  wr_be_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ls_align_unit i_ls_align_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] f_addr(logic [4:0] idx, logic [63:0] b, logic [15:0] d);
    logic [63:0] base = (idx == 0) ? 64'd0 : b;
    return base + {{48{d[15]}}, d};
  endfunction

  function automatic bit f_mis(logic [1:0] sz, logic [63:0] a);
    int n = 1 << sz;
    return (a % n) != 0;
  endfunction

  function automatic int f_lane(bit be, int a, int n, int i);
    return be ? (8 - a - n + i) : (a + i);
  endfunction

  task automatic one(input bit st, input logic [1:0] sz, input bit uns, input bit be,
                     input logic [4:0] idx, input logic [63:0] b, input logic [15:0] d,
                     input logic [63:0] src, input logic [63:0] rd);
    logic [63:0] ea, exp_data, exp_ld;
    logic [7:0]  exp_be;
    bit mis;
    int n, a;
    @(negedge clk_i);
    req_valid_i = 1; req_store_i = st; req_size_i = sz; req_unsigned_i = uns;
    big_endian_i = be; base_idx_i = idx; base_val_i = b; disp_i = d;
    store_src_i = src; mem_rdata_i = rd;
    ea = f_addr(idx, b, d); mis = f_mis(sz, ea);
    n = 1 << sz; a = int'(ea[2:0]);
    exp_be = '0; exp_data = '0; exp_ld = '0;
    if (!mis) begin
      for (int i = 0; i < n; i++) begin
        int l = f_lane(be, a, n, i);
        if (st) begin
          exp_be[l] = 1'b1;
          exp_data[l*8 +: 8] = src[i*8 +: 8];
        end
        exp_ld[i*8 +: 8] = rd[l*8 +: 8];
      end
      if (!uns && n < 8 && exp_ld[n*8-1])
        for (int k = n * 8; k < 64; k++) exp_ld[k] = 1'b1;
    end
    #1;
    chk(addr_o == ea, (idx == 0) ? "R2 base0" : "R1 addr", addr_o, ea);
    chk(fault_o == mis, "R3 fault", {63'd0, fault_o}, {63'd0, mis});
    chk(wr_be_o == exp_be, st ? "R5 be" : "R4 be load", {56'd0, wr_be_o}, {56'd0, exp_be});
    if (st && !mis) chk(wr_data_o == exp_data, "R6 sdata", wr_data_o, exp_data);
    @(posedge clk_i); #1;
    chk(load_valid_o == !st, "R8 lvalid", {63'd0, load_valid_o}, {63'd0, !st});
    if (!st) begin
      chk(load_fault_o == mis, "R9 lfault", {63'd0, load_fault_o}, {63'd0, mis});
      chk(load_data_o == exp_ld, mis ? "R9 ldata0" : "R7 ldata", load_data_o, exp_ld);
    end
    @(negedge clk_i);
    req_valid_i = 0;
    #1;
    chk(wr_be_o == 8'h00 && fault_o == 1'b0, "R4 idle", {56'd0, wr_be_o}, 64'd0);
    @(posedge clk_i); #1;
    chk(load_valid_o == 1'b0, "R8 idle", {63'd0, load_valid_o}, 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    #3;
    chk(load_valid_o == 0 && load_fault_o == 0 && load_data_o == 0, "R10 reset",
        load_data_o, 64'd0);
    #20 rst_ni = 1;
    // directed corners
    one(0, 2'd0, 0, 0, 5'd3, 64'h100, 16'h0005, 0, 64'h0000_80FF_0000_0000);
    one(0, 2'd0, 1, 1, 5'd3, 64'h100, 16'h0002, 0, 64'h0000_80FF_0000_0000);
    one(0, 2'd1, 0, 1, 5'd0, 64'hDEAD, 16'h0010, 0, 64'h8123_4567_89AB_CDEF);
    one(0, 2'd2, 0, 0, 5'd1, 64'h1000, 16'hFFFC, 0, 64'hF000_0000_8000_0001);
    one(0, 2'd3, 0, 1, 5'd2, 64'h8, 16'h0000, 0, 64'h0123_4567_89AB_CDEF);
    one(0, 2'd2, 0, 0, 5'd2, 64'h3, 16'h0000, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    one(1, 2'd3, 0, 0, 5'd4, 64'h0, 16'h0004, 64'h1122_3344_5566_7788, 0);
    one(1, 2'd1, 0, 1, 5'd4, 64'hFFFF_FFFF_FFFF_FFFE, 16'h0008, 64'hAABB, 0);
    one(1, 2'd2, 0, 1, 5'd4, 64'h4, 16'h0000, 64'h99_CAFE_F00D, 0);
    one(1, 2'd1, 0, 0, 5'd4, 64'h5, 16'h0000, 64'h1234, 0);
    for (int t = 0; t < 400; t++) begin
      logic [63:0] b = {$urandom, $urandom};
      logic [15:0] d = 16'($urandom);
      if ($urandom_range(0, 3) != 0) begin
        b[2:0] = 3'd0;
        d[2:0] = 3'($urandom_range(0, 7)) & ~3'($urandom_range(0, 7));
      end
      one(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 5'($urandom_range(0, 7)),
          b, d, {$urandom, $urandom}, {$urandom, $urandom});
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule